// File: doc/BRIEF.md
# Synthesizer Calibration and Lock Sequencer

This controller decides when the frequency synthesizer's oscillator and loop calibration runs. It also tells the rest of the radio when the synthesizer may be used. It watches the radio's requested state (idle, active or sleep), a two-bit calibration mode field, a manual calibrate strobe and a frequency-change pulse from the register block. From these it drives a calibration-enable line to the analog synthesizer and a synthesizer-enable line.

A calibration attempt lasts a fixed number of reference clock cycles. On the last cycle of an attempt the block samples a status code returned by the analog circuitry. An all-ones code means the loop did not lock, and the block then starts another attempt at once. Once it succeeds it marks the calibration valid. When the success came from a turn-on, it enables the synthesizer and raises a lock-detect output that can serve as a rising-edge interrupt.

If too many attempts fail in a row, a sticky error is raised. A valid calibration survives sleep. A frequency change discards it, so a calibration must run before the next turn-on.

Top module: `synth_cal_seq`

## Requirements
- R1: After reset, cal_en_o, synth_en_o, lock_o and cal_err_o are all low, and the stored calibration is invalid.
- R2: A cal_strobe_i pulse while the sequencer is idle starts a calibration, and the sequencer returns to idle once it succeeds. This holds even when radio_state_i is active, and in that case the sequencer turns the synthesizer on in the following cycle.
- R3: cal_strobe_i has no effect while the synthesizer is on, while in sleep, or during a calibration.
- R4: cal_mode_i encodings are 2'b00 manual, 2'b01 calibrate on every turn-on, 2'b10 calibrate on every turn-off, and 2'b11 behaves as manual. In mode 2'b01 every turn-on runs a calibration before synth_en_o rises.
- R5: In mode 2'b10, leaving the active state runs one calibration with synth_en_o low, and the sequencer then goes to idle.
- R6: A turn-on (radio_state_i = 2'b01) with no valid calibration runs a calibration before synth_en_o rises, in every mode. A turn-on with a valid calibration in manual mode raises synth_en_o one cycle later, with no calibration.
- R7: cal_en_o stays high for exactly CAL_CYCLES cycles per attempt, and it is never high together with synth_en_o.
- R8: An attempt succeeds when cal_status_i, sampled in its last cycle, differs from all ones (6'h3F). lock_o rises in the same cycle that synth_en_o rises after a success, and lock_o is never high while synth_en_o is low.
- R9: A failed attempt is followed immediately by a new attempt, with cal_en_o held high without a gap.
- R10: After MAX_TRIES consecutive failed attempts, cal_err_o goes high, the calibration is invalid and the sequencer returns to idle. It makes no automatic retry while cal_err_o is high. A later successful calibration clears cal_err_o.
- R11: Sleep (radio_state_i = 2'b10) keeps a valid calibration, so a turn-on after waking needs none in manual mode.
- R12: A freq_chg_i pulse invalidates the stored calibration. It drops lock_o if the synthesizer is on, and it forces a calibration at the next turn-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| radio_state_i | input | 2 | Requested radio state: 00 idle, 01 active, 10 sleep, 11 idle |
| cal_mode_i | input | 2 | Calibration mode: 00 manual, 01 on turn-on, 10 on turn-off, 11 manual |
| cal_strobe_i | input | 1 | Manual calibrate request |
| freq_chg_i | input | 1 | Frequency or channel setting changed |
| cal_status_i | input | STAT_W | Calibration status code from the analog synthesizer |
| cal_en_o | output | 1 | Calibration running, to the analog synthesizer |
| synth_en_o | output | 1 | Synthesizer enabled |
| lock_o | output | 1 | Lock detect, high while on with a valid calibration |
| cal_err_o | output | 1 | Sticky calibration failure |

## Verification
Any input change takes effect one clock edge after it is driven. cal_en_o or synth_en_o therefore moves in the cycle after a strobe or state change. The end of a calibration shows up exactly CAL_CYCLES cycles after cal_en_o rises, or a multiple of that when attempts are retried, and lock_o and synth_en_o rise in that same cycle. The bench drives inputs on falling edges and samples outputs on falling edges. It measures each calibration as the run of consecutive falling edges with cal_en_o high, and compares that length with CAL_CYCLES times the expected number of attempts. It reads the outputs at the first falling edge after the run to confirm the state that follows.

// File: rtl/synth_cal_pkg.sv
package synth_cal_pkg;
  localparam logic [1:0] RADIO_IDLE   = 2'b00;
  localparam logic [1:0] RADIO_ACTIVE = 2'b01;
  localparam logic [1:0] RADIO_SLEEP  = 2'b10;

  localparam logic [1:0] MODE_MANUAL   = 2'b00;
  localparam logic [1:0] MODE_AUTO_ON  = 2'b01;
  localparam logic [1:0] MODE_AUTO_OFF = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_CAL   = 2'b01,
    ST_ON    = 2'b10,
    ST_SLEEP = 2'b11
  } seq_state_e;
endpackage

// File: rtl/synth_cal_timer.sv
module synth_cal_timer #(
  parameter int CAL_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int CNT_W = (CAL_CYCLES > 2) ? $clog2(CAL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CAL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == CNT_LAST);

  // wraps on the last cycle so a retry starts a fresh window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (last_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/synth_cal_lock_eval.sv
module synth_cal_lock_eval #(
  parameter int STAT_W = 6
) (
  input  logic [STAT_W-1:0] status_i,
  output logic              locked_o
);
  // all ones from the analog side means the loop failed to lock
  localparam logic [STAT_W-1:0] NO_LOCK = '1;

  assign locked_o = (status_i != NO_LOCK);
endmodule

// File: rtl/synth_cal_retry.sv
module synth_cal_retry #(
  parameter int MAX_TRIES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic fail_i,
  output logic exhaust_o
);
  localparam int TRY_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES + 1) : 1;
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES - 1);

  logic [TRY_W-1:0] fails_q;

  assign exhaust_o = fail_i && (fails_q == TRY_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    fails_q <= '0;
    else if (clear_i || exhaust_o)  fails_q <= '0;
    else if (fail_i)                fails_q <= fails_q + 1'b1;
  end

  a_r10_fails_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fails_q <= TRY_LAST);
  a_r10_exhaust_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exhaust_o |=> fails_q == '0);
endmodule

// File: rtl/synth_cal_seq.sv
module synth_cal_seq
  import synth_cal_pkg::*;
#(
  parameter int CAL_CYCLES = 16,
  parameter int MAX_TRIES  = 3,
  parameter int STAT_W     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        radio_state_i,
  input  logic [1:0]        cal_mode_i,
  input  logic              cal_strobe_i,
  input  logic              freq_chg_i,
  input  logic [STAT_W-1:0] cal_status_i,
  output logic              cal_en_o,
  output logic              synth_en_o,
  output logic              lock_o,
  output logic              cal_err_o
);
  seq_state_e state_q, state_d;
  logic go_on_q, go_on_d;
  logic valid_q, err_q;
  logic last, locked, exhaust;
  logic want_on, cal_ok, cal_bad;

  synth_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_CAL),
    .last_o (last)
  );

  synth_cal_lock_eval #(.STAT_W(STAT_W)) u_lock (
    .status_i (cal_status_i),
    .locked_o (locked)
  );

  synth_cal_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (state_q != ST_CAL),
    .fail_i    (last && !locked),
    .exhaust_o (exhaust)
  );

  assign want_on = (radio_state_i == RADIO_ACTIVE);
  assign cal_ok  = last && locked;
  assign cal_bad = exhaust;

  always_comb begin
    state_d = state_q;
    go_on_d = go_on_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cal_strobe_i) begin
          state_d = ST_CAL;
          go_on_d = 1'b0;
        end else if (want_on) begin
          if (!valid_q || cal_mode_i == MODE_AUTO_ON) begin
            if (!err_q) begin
              state_d = ST_CAL;
              go_on_d = 1'b1;
            end
          end else begin
            state_d = ST_ON;
          end
        end else if (radio_state_i == RADIO_SLEEP) begin
          state_d = ST_SLEEP;
        end
      end
      ST_CAL: begin
        if (cal_ok)       state_d = (go_on_q && want_on) ? ST_ON : ST_IDLE;
        else if (cal_bad) state_d = ST_IDLE;
      end
      ST_ON: begin
        if (!want_on) begin
          state_d = (cal_mode_i == MODE_AUTO_OFF) ? ST_CAL : ST_IDLE;
          go_on_d = 1'b0;
        end
      end
      ST_SLEEP: begin
        if (radio_state_i != RADIO_SLEEP) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      go_on_q <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      go_on_q <= go_on_d;
      // a frequency change outranks a success in the same cycle
      if (freq_chg_i)   valid_q <= 1'b0;
      else if (cal_ok)  valid_q <= 1'b1;
      else if (cal_bad) valid_q <= 1'b0;
      if (cal_ok)       err_q <= 1'b0;
      else if (cal_bad) err_q <= 1'b1;
    end
  end

  assign cal_en_o   = (state_q == ST_CAL);
  assign synth_en_o = (state_q == ST_ON);
  assign lock_o     = synth_en_o && valid_q;
  assign cal_err_o  = err_q;

  a_r7_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cal_en_o && synth_en_o));
  a_r8_lock_needs_synth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> synth_en_o);
  a_r3_on_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && want_on) |=> state_q == ST_ON);
  a_r3_sleep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && radio_state_i == RADIO_SLEEP) |=> state_q == ST_SLEEP);
  a_r11_sleep_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && !freq_chg_i) |=> $stable(valid_q));
  a_r10_err_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && err_q && !cal_strobe_i) |=> state_q != ST_CAL);
  a_r9_retry_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CAL && last && !locked && !exhaust) |=> state_q == ST_CAL);
  a_r12_chg_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_chg_i |=> !lock_o);
endmodule

// File: tb/tb_synth_cal_seq.sv
module tb_synth_cal_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CAL = 16;
  localparam int TRIES = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rstate = 2'b00;
  logic [1:0] mode = 2'b00;
  logic strobe = 1'b0;
  logic fchg = 1'b0;
  logic [5:0] status;
  logic cal_en, synth_en, lock, err;

  int total = 0;
  int bad = 0;

  // analog model: counts finished attempts, reports no-lock for the first fails_want
  int cyc = 0;
  int att = 0;
  int base = 0;
  int fails_want = 0;
  assign status = ((att - base) < fails_want) ? 6'h3F : 6'h15;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else if (cal_en) begin
      if (cyc == CAL - 1) begin
        cyc <= 0;
        att <= att + 1;
      end else cyc <= cyc + 1;
    end else cyc <= 0;
  end

  synth_cal_seq #(.CAL_CYCLES(CAL), .MAX_TRIES(TRIES), .STAT_W(6)) dut (
    .clk_i(clk), .rst_ni(rst_n), .radio_state_i(rstate), .cal_mode_i(mode),
    .cal_strobe_i(strobe), .freq_chg_i(fchg), .cal_status_i(status),
    .cal_en_o(cal_en), .synth_en_o(synth_en), .lock_o(lock), .cal_err_o(err)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1; step(1); strobe = 1'b0;
  endtask

  task automatic pulse_fchg();
    fchg = 1'b1; step(1); fchg = 1'b0;
  endtask

  task automatic set_fails(input int n);
    base = att;
    fails_want = n;
  endtask

  // length of the next cal_en run; flags lock or synth seen high during it
  task automatic measure(output int len, output bit lock_seen, output bit synth_seen);
    len = 0; lock_seen = 0; synth_seen = 0;
    for (int i = 0; i < 10 && !cal_en; i++) step(1);
    while (cal_en && len < 1000) begin
      len++;
      if (lock) lock_seen = 1;
      if (synth_en) synth_seen = 1;
      step(1);
    end
  endtask

  // returns number of cycles with cal_en high over n cycles
  task automatic watch(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (cal_en) hits++;
    end
  endtask

  task automatic t_reset();
    chk(!cal_en && !synth_en && !lock && !err, "R1 reset outputs",
        {cal_en, synth_en, lock, err}, 0);
  endtask

  task automatic t_powerup();
    int len; bit ls, ss;
    rstate = 2'b01;
    measure(len, ls, ss);
    chk(len == CAL, "R6 R7 power-up cal length", len, CAL);
    chk(!ls && !ss, "R8 no lock or synth during cal", {ls, ss}, 0);
    chk(synth_en && lock, "R8 lock rises with synth", {synth_en, lock}, 3);
  endtask

  task automatic t_manual_cycle();
    int hits;
    rstate = 2'b00;
    watch(2, hits);
    chk(hits == 0 && !synth_en && !lock, "R4 manual turn-off no cal", hits, 0);
    rstate = 2'b01;
    step(1);
    chk(synth_en && lock && !cal_en, "R6 valid turn-on immediate", {synth_en, lock, cal_en}, 6);
  endtask

  task automatic t_strobe_on();
    int hits;
    strobe = 1'b1;
    watch(1, hits);
    strobe = 1'b0;
    begin
      int h2;
      watch(5, h2);
      hits += h2;
    end
    chk(hits == 0 && synth_en, "R3 strobe ignored while on", hits, 0);
  endtask

  task automatic t_strobe_idle();
    int len; bit ls, ss;
    rstate = 2'b00;
    step(2);
    pulse_strobe();
    measure(len, ls, ss);
    chk(len == CAL, "R2 manual cal length", len, CAL);
    chk(!synth_en && !cal_en, "R2 back to idle", {synth_en, cal_en}, 0);
  endtask

  task automatic t_auto_on();
    int len; bit ls, ss;
    mode = 2'b01;
    rstate = 2'b01;
    measure(len, ls, ss);
    chk(len == CAL && synth_en, "R4 auto-on first turn-on", len, CAL);
    rstate = 2'b00; step(2);
    rstate = 2'b01;
    measure(len, ls, ss);
    chk(len == CAL && synth_en && lock, "R4 auto-on second turn-on", len, CAL);
    rstate = 2'b00; step(2);
    mode = 2'b00;
  endtask

  task automatic t_auto_off();
    int len; bit ls, ss;
    mode = 2'b10;
    rstate = 2'b01;
    step(1);
    chk(synth_en && !cal_en, "R5 valid turn-on skips cal", {synth_en, cal_en}, 2);
    rstate = 2'b00;
    measure(len, ls, ss);
    chk(len == CAL, "R5 turn-off cal length", len, CAL);
    chk(!ss && !synth_en && !lock, "R5 synth low during and after", {ss, synth_en, lock}, 0);
    mode = 2'b00;
    step(1);
  endtask

  task automatic t_sleep();
    int hits, h2;
    rstate = 2'b10;
    step(2);
    pulse_strobe();
    watch(5, hits);
    chk(hits == 0 && !cal_en, "R3 strobe ignored in sleep", hits, 0);
    rstate = 2'b00; step(2);
    rstate = 2'b01;
    watch(1, h2);
    chk(h2 == 0 && synth_en && lock, "R11 wake keeps calibration", {h2, synth_en, lock}, 3);
  endtask

  task automatic t_freq();
    int len; bit ls, ss;
    pulse_fchg();
    chk(synth_en && !lock, "R12 lock drops on freq change", {synth_en, lock}, 2);
    rstate = 2'b00; step(2);
    rstate = 2'b01;
    measure(len, ls, ss);
    chk(len == CAL && synth_en && lock, "R12 recal after freq change", len, CAL);
    rstate = 2'b00; step(2);
  endtask

  task automatic t_retry();
    int len; bit ls, ss;
    pulse_fchg();
    set_fails(2);
    rstate = 2'b01;
    measure(len, ls, ss);
    chk(len == 3 * CAL, "R9 retry gapless length", len, 3 * CAL);
    chk(synth_en && lock && !err, "R9 lock after retries", {synth_en, lock, err}, 6);
    rstate = 2'b00; step(2);
    set_fails(0);
  endtask

  task automatic t_exhaust();
    int len, hits; bit ls, ss;
    pulse_fchg();
    set_fails(10);
    rstate = 2'b01;
    measure(len, ls, ss);
    chk(len == TRIES * CAL, "R10 attempts before error", len, TRIES * CAL);
    chk(err && !synth_en && !lock, "R10 error raised, synth off", {err, synth_en, lock}, 4);
    watch(10, hits);
    chk(hits == 0 && err, "R10 no auto retry while error", hits, 0);
    set_fails(0);
    pulse_strobe();
    measure(len, ls, ss);
    chk(len == CAL && !err, "R10 success clears error", {len, err}, CAL);
    step(1);
    chk(synth_en && lock, "R2 turn-on after strobe cal", {synth_en, lock}, 3);
    rstate = 2'b00; step(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_powerup();
    t_manual_cycle();
    t_strobe_on();
    t_strobe_idle();
    t_auto_on();
    t_auto_off();
    t_sleep();
    t_freq();
    t_retry();
    t_exhaust();
    summary();
    $finish;
  end
endmodule